// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog counter with two independent limits. While counting is allowed, the counter goes up by one every clock. When the count reaches the first limit (the warning stage), the block raises a level interrupt and an identical copy meant for a non-maskable interrupt line. If the control register enables it, the block also raises a level wakeup request for the power controller. These warning outputs stay high until software acknowledges them or the block is reset. When the count reaches the second limit (the fatal stage), the block raises a reset request. That request stays high until the block itself is reset.

Software keeps the watchdog quiet by writing zero to the count register at regular intervals. After setup, software can freeze the control and limit registers by clearing a one-way enable bit. Count writes stay open so that petting still works. Counting stops when the enable bit is clear, when the escalation input is high, or when the run input is low. If the pause-in-sleep option is set, counting also stops while the low-power input is high.

Top module: `wdog_timer`

Register map (write port `reg_waddr`, read port `reg_raddr`):
- Address 0: control. Bit 0 enables counting, bit 1 pauses counting in sleep, bit 2 enables the wakeup request on the warning stage.
- Address 1: warning limit.
- Address 2: fatal limit.
- Address 3: count.
- Address 4: configuration write enable, bit 0.
- Address 5: acknowledge, write-only, reads as 0. Writing bit 0 = 1 clears the interrupt; writing bit 1 = 1 clears the wakeup request.

## Requirements
- R1: After reset the count is 0, control reads 0, both limits read all ones, the write-enable bit reads 1, and all four event outputs are low.
- R2: While counting is allowed and no count write occurs, the count increases by exactly 1 per clock. At all ones it saturates and stays there.
- R3: A clock edge at which counting is allowed and count >= warning limit sets `bark_irq_o` and `bark_nmi_o` from the next cycle on. Starting from a count of 0 with enable written at edge 0, they are first high after edge L+1, where L is the warning limit.
- R4: `wake_req_o` is set together with the interrupt only when control bit 2 is 1. Otherwise it stays low.
- R5: Writing 1 to acknowledge bit 0 clears the interrupt pair, and writing 1 to bit 1 clears the wakeup request; each bit leaves the other output alone. If the warning condition still holds at that edge, the interrupt stays set.
- R6: `bite_rst_o` is set after an edge at which counting is allowed and count >= fatal limit. It stays high through acknowledges, count writes and disabling, and clears only on reset.
- R7: A write to the count register loads the written value at that edge, whether or not the configuration is locked.
- R8: Writing 0 to bit 0 of address 4 clears the write enable for good, until reset. Writing 1 to it has no effect. While it is clear, writes to control and both limits are ignored.
- R9: With control bit 1 set, the count holds while `sleep_i` is high. With bit 1 clear, `sleep_i` has no effect.
- R10: While `esc_i` is high or `run_i` is low, the count holds and neither the interrupt nor the reset request gets set.
- R11: With control bit 0 clear, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| sleep_i | input | 1 | Low-power state indication |
| esc_i | input | 1 | Escalation active |
| run_i | input | 1 | External counter-run permission |
| bark_irq_o | output | 1 | Warning-stage level interrupt |
| bark_nmi_o | output | 1 | Warning-stage non-maskable copy |
| wake_req_o | output | 1 | Warning-stage wakeup request |
| bite_rst_o | output | 1 | Fatal-stage reset request |

## Verification
The warning limit is swept from 0 to 6, with the wakeup enable bit alternating. Each run checks the count after every edge and the edge at which the interrupt pair and the wakeup request first appear; this tells a >= compare apart from a > or == compare, and catches an off-by-one in the registered flag. Each gating input (sleep with and without the pause bit, escalation, run) is applied on its own, so a wrong term in the enable logic shows up as a count that moves or holds when it should not. The count is loaded just below all ones to show saturation. The lock is tried with both data polarities on the write-enable bit, followed by writes to control, a limit and the count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_BARK   = 3'd1,
    A_BITE   = 3'd2,
    A_COUNT  = 3'd3,
    A_UNLOCK = 3'd4,
    A_ACK    = 3'd5
  } reg_addr_e;

  // control register, bit 2 .. bit 0
  typedef struct packed {
    logic wake_on_bark;
    logic pause_sleep;
    logic enable;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     waddr,
  input  logic [CNT_W-1:0]      wdata,
  output ctrl_t                 ctrl,
  output logic [CNT_W-1:0]      bark_lim,
  output logic [CNT_W-1:0]      bite_lim,
  output logic                  unlocked
);

  logic cfg_wr;     // a write aimed at a lockable register
  logic cfg_take;   // such a write that is allowed
  logic lock_req;

  assign cfg_wr   = we && (waddr == A_CTRL || waddr == A_BARK || waddr == A_BITE);
  assign cfg_take = cfg_wr && unlocked;
  assign lock_req = we && (waddr == A_UNLOCK) && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      bark_lim <= '1;
      bite_lim <= '1;
      unlocked <= 1'b1;
    end else begin
      if (lock_req) unlocked <= 1'b0;
      if (cfg_take) begin
        case (waddr)
          A_CTRL:  ctrl     <= ctrl_t'(wdata[CTRL_W-1:0]);
          A_BARK:  bark_lim <= wdata;
          A_BITE:  bite_lim <= wdata;
          default: ;
        endcase
      end
    end
  end

  p_frozen_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !unlocked) |=> ($stable(ctrl) && $stable(bark_lim) && $stable(bite_lim)));

  p_lock_oneway_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> !unlocked);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             pet_we,
  input  logic [CNT_W-1:0] pet_val,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (pet_we) cnt <= pet_val;
    else if (active) cnt <= sat_inc(cnt);
  end

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !pet_we) |=> $stable(cnt));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pet_we && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

  p_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pet_we && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  p_pet_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pet_we |=> (cnt == $past(pet_val)));

endmodule

// File: rtl/wdog_events.sv
module wdog_events #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] bark_lim,
  input  logic [CNT_W-1:0] bite_lim,
  input  logic             wake_en,
  input  logic             ack_irq,
  input  logic             ack_wake,
  output logic             irq_q,
  output logic             wake_q,
  output logic             bite_q
);

  function automatic logic reached(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] lim);
    return v >= lim;
  endfunction

  logic bark_hit;
  logic bite_hit;

  assign bark_hit = active && reached(cnt, bark_lim);
  assign bite_hit = active && reached(cnt, bite_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
      bite_q <= 1'b0;
    end else begin
      if (bark_hit)          irq_q  <= 1'b1;
      else if (ack_irq)      irq_q  <= 1'b0;
      if (bark_hit && wake_en) wake_q <= 1'b1;
      else if (ack_wake)     wake_q <= 1'b0;
      if (bite_hit)          bite_q <= 1'b1;
    end
  end

  p_bark_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bark_hit |=> irq_q);

  p_wake_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_q && !(bark_hit && wake_en)) |=> !wake_q);

  p_bite_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bite_q |=> bite_q);

  p_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !irq_q) |=> !irq_q);

  p_quiet_bite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !bite_q) |=> !bite_q);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              sleep_i,
  input  logic              esc_i,
  input  logic              run_i,
  output logic              bark_irq_o,
  output logic              bark_nmi_o,
  output logic              wake_req_o,
  output logic              bite_rst_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] bark_lim;
  logic [CNT_W-1:0] bite_lim;
  logic [CNT_W-1:0] cnt;
  logic             unlocked;
  logic             active;
  logic             pet_we;
  logic             ack_irq;
  logic             ack_wake;
  logic             irq_q;
  logic             wake_q;
  logic             bite_q;

  // named event wires
  assign active   = ctrl.enable && run_i && !esc_i && !(ctrl.pause_sleep && sleep_i);
  assign pet_we   = reg_we && (reg_waddr == A_COUNT);
  assign ack_irq  = reg_we && (reg_waddr == A_ACK) && reg_wdata[0];
  assign ack_wake = reg_we && (reg_waddr == A_ACK) && reg_wdata[1];

  wdog_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .waddr    (reg_waddr),
    .wdata    (reg_wdata),
    .ctrl     (ctrl),
    .bark_lim (bark_lim),
    .bite_lim (bite_lim),
    .unlocked (unlocked)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .pet_we  (pet_we),
    .pet_val (reg_wdata),
    .cnt     (cnt)
  );

  wdog_events #(.CNT_W(CNT_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .cnt      (cnt),
    .bark_lim (bark_lim),
    .bite_lim (bite_lim),
    .wake_en  (ctrl.wake_on_bark),
    .ack_irq  (ack_irq),
    .ack_wake (ack_wake),
    .irq_q    (irq_q),
    .wake_q   (wake_q),
    .bite_q   (bite_q)
  );

  always_comb begin
    case (reg_raddr)
      A_CTRL:   reg_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
      A_BARK:   reg_rdata = bark_lim;
      A_BITE:   reg_rdata = bite_lim;
      A_COUNT:  reg_rdata = cnt;
      A_UNLOCK: reg_rdata = {{(CNT_W-1){1'b0}}, unlocked};
      default:  reg_rdata = '0;
    endcase
  end

  assign bark_irq_o = irq_q;
  assign bark_nmi_o = irq_q;
  assign wake_req_o = wake_q;
  assign bite_rst_o = bite_q;

  p_stall_gates_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((esc_i || !run_i) && !pet_we) |=> $stable(cnt));

  p_disabled_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.enable && !pet_we) |=> $stable(cnt));

  p_sleep_pause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pause_sleep && sleep_i && !pet_we) |=> $stable(cnt));

endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        sleep_i = 1'b0;
  logic        esc_i = 1'b0;
  logic        run_i = 1'b1;
  logic        bark_irq_o, bark_nmi_o, wake_req_o, bite_rst_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .sleep_i(sleep_i), .esc_i(esc_i), .run_i(run_i),
    .bark_irq_o(bark_irq_o), .bark_nmi_o(bark_nmi_o),
    .wake_req_o(wake_req_o), .bite_rst_o(bite_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    edges(2);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    edges(2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3, v); chk("R1 count", v, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 bark limit", v, 32'hFFFF_FFFF);
    rd(2, v); chk("R1 bite limit", v, 32'hFFFF_FFFF);
    rd(4, v); chk("R1 unlock", v, 1);
    chk("R1 outputs", {bark_irq_o, bark_nmi_o, wake_req_o, bite_rst_o}, 0);

    // R11 disabled counter holds
    edges(5);
    rd(3, v); chk("R11 disabled hold", v, 0);

    // R2 R3 R4 sweep of the warning limit
    for (int b = 0; b <= 6; b++) begin
      logic we_bit;
      we_bit = b[0];
      wr(0, 0); wr(3, 0); wr(1, b); wr(2, 1000); wr(5, 3);
      chk("R5 cleared before run", {bark_irq_o, wake_req_o}, 0);
      wr(0, {29'd0, we_bit, 1'b0, 1'b1});
      for (int n = 1; n <= b + 3; n++) begin
        logic e;
        @(negedge clk);
        e = (n >= b + 1);
        rd(3, v); chk("R2 count step", v, n);
        chk("R3 irq edge", bark_irq_o, e);
        chk("R3 nmi edge", bark_nmi_o, e);
        chk("R4 wake gating", wake_req_o, e & we_bit);
      end
    end

    // R9 pause in sleep
    wr(0, 0); wr(5, 3); wr(1, 1000); wr(3, 0);
    wr(0, 32'h3);
    sleep_i = 1'b1;
    edges(4);
    rd(3, v); chk("R9 paused in sleep", v, 0);
    sleep_i = 1'b0;
    edges(4);
    rd(3, v); chk("R9 resumes after sleep", v, 4);
    wr(0, 32'h1);
    sleep_i = 1'b1;
    wr(3, 0);
    edges(3);
    rd(3, v); chk("R9 sleep ignored without pause bit", v, 3);
    sleep_i = 1'b0;

    // R10 escalation and run gating
    esc_i = 1'b1;
    wr(3, 0); wr(1, 0);
    edges(4);
    rd(3, v); chk("R10 esc holds count", v, 0);
    chk("R10 esc blocks bark", bark_irq_o, 0);
    esc_i = 1'b0;
    run_i = 1'b0;
    edges(4);
    rd(3, v); chk("R10 run low holds count", v, 0);
    chk("R10 run low blocks bark", bark_irq_o, 0);
    run_i = 1'b1;
    edges(1);
    chk("R10 bark after release", bark_irq_o, 1);

    // R5 acknowledge behaviour
    wr(0, 0); wr(5, 3); wr(3, 0); wr(1, 2);
    wr(0, 32'h5);
    edges(6);
    chk("R5 irq up", bark_irq_o, 1);
    chk("R5 wake up", wake_req_o, 1);
    wr(5, 1);
    chk("R5 ack overridden while still past limit", bark_irq_o, 1);
    wr(0, 0);
    wr(5, 1);
    chk("R5 irq cleared", bark_irq_o, 0);
    chk("R5 nmi cleared", bark_nmi_o, 0);
    chk("R5 wake kept by irq ack", wake_req_o, 1);
    wr(5, 2);
    chk("R5 wake cleared", wake_req_o, 0);

    // R6 fatal stage
    wr(1, 1000); wr(2, 3); wr(3, 0);
    wr(0, 32'h1);
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      chk("R6 bite edge", bite_rst_o, (n >= 4));
    end
    wr(5, 3); wr(3, 0); wr(0, 0);
    edges(2);
    chk("R6 bite sticky", bite_rst_o, 1);
    chk("R6 bite apart from bark", bark_irq_o, 0);
    do_reset();
    @(negedge clk);
    chk("R6 bite cleared by reset", bite_rst_o, 0);
    rd(3, v); chk("R1 count after reset", v, 0);

    // R2 saturation
    wr(1, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFD);
    wr(0, 32'h1);
    edges(5);
    rd(3, v); chk("R2 saturation", v, 32'hFFFF_FFFF);
    wr(0, 0);

    // R8 lock, R7 pet under lock
    wr(4, 1);
    rd(4, v); chk("R8 writing one keeps unlocked", v, 1);
    wr(1, 55);
    rd(1, v); chk("R8 write accepted before lock", v, 55);
    wr(4, 0);
    rd(4, v); chk("R8 locked", v, 0);
    wr(1, 77);
    rd(1, v); chk("R8 bark limit frozen", v, 55);
    wr(2, 88);
    rd(2, v); chk("R8 bite limit frozen", v, 32'hFFFF_FFFF);
    wr(4, 1);
    rd(4, v); chk("R8 cannot relock open", v, 0);
    wr(0, 32'h7);
    rd(0, v); chk("R8 ctrl frozen", v, 0);
    wr(3, 123);
    rd(3, v); chk("R7 pet while locked", v, 123);
    edges(3);
    rd(3, v); chk("R11 locked disabled hold", v, 123);

    finish_run();
  end

endmodule